// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a logic array whose function is loaded at run time instead of being burned in. Sixteen data inputs feed 48 product terms. Each term is the AND of one literal per input, and each literal picks the true input, its complement, don't care, or a kill value that holds the term at 0. An OR matrix lets any term feed any of the 8 outputs, and one term may feed several outputs at once. A per-output invert bit then selects the sum of products or its complement.

The path from `data_in` to the outputs is purely combinational. Only the configuration store is clocked, and it is written through a simple write-enable / address / data port. An active-low chip enable inhibits every output. A build parameter picks how an inhibited output appears:

- **Tri-state style:** the line floats.
- **Open-collector emulation:** each line is modelled as an active-low pull-down enable plus the resolved level the wire would show, and an inhibited line is released high.

Top module: `sop_array`

## Requirements
- R1: After reset every literal holds the kill code, every OR row is empty and the invert register is clear, so every enabled output reads 0.
- R2: The literal for input i of term t sits in bits [2i+1:2i] of the word at address t (0..47). The codes are 00 don't care, 01 true input, 10 complemented input, and 11 term forced to 0.
- R3: A term whose literals are all don't care evaluates to 1 for every input pattern.
- R4: Bit t of the OR row at address 48+k connects term t to output k. A term connected to several outputs drives all of them.
- R5: An output with no connected term has a pre-invert value of 0.
- R6: Bit k of the invert register at address 56 complements output k.
- R7: A configuration write becomes visible only after the next rising clock edge. Changes on `data_in` reach the outputs within the same cycle, with no clock.
- R8: While `ce_n` is 1, `drv_n` is all ones whatever the array computes. In tri-state style `f_out` is high impedance.
- R9: In tri-state style an enabled chip drives `f_out` with the array value and `drv_n` is 0. In open-collector style an output pulls low (`drv_n`=0) exactly when its value is 0, and `f_out` equals `drv_n`, including the released level 1 when the chip is inhibited.
- R10: A write to an address above 56 changes no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 48 | Configuration write data |
| data_in | input | 16 | Array data inputs |
| ce_n | input | 1 | Active-low chip enable |
| f_out | output | 8 | Output lines (tri-state or resolved open-collector level) |
| drv_n | output | 8 | Active-low drive / pull-down enable per output |

## Verification
On every cycle the assertions check four things:

- The inhibit rule: `drv_n` is all ones while disabled and all zeros while enabled in tri-state style.
- The open-collector resolution: `f_out` equals `drv_n`.
- That ignored addresses leave the store untouched.
- That the outputs hold still when neither a write nor the inputs change.

They also check that any all-don't-care term fires. The literal decoding, term sharing across outputs, inversion and the one-edge write latency can only be shown by the bench. It compares both output styles against a software model of the array while loading directed and random configurations.

// File: rtl/sop_pkg.sv
package sop_pkg;
    typedef enum logic [1:0] {
        LIT_ANY  = 2'b00,
        LIT_POS  = 2'b01,
        LIT_NEG  = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 48
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [N_TERM*2*N_IN-1:0]   term_cfg,
    output logic [N_OUT*N_TERM-1:0]    or_cfg,
    output logic [N_OUT-1:0]           inv_cfg
);
    localparam int LIT_W    = 2 * N_IN;
    localparam int OR_BASE  = N_TERM;
    localparam int INV_ADDR = N_TERM + N_OUT;

    // Literal words, one per product term
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [LIT_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '1;
            else if (cfg_we && cfg_addr == ADDR_W'(t))
                word_q <= cfg_wdata[LIT_W-1:0];
        end
        assign term_cfg[t*LIT_W +: LIT_W] = word_q;
    end

    // OR-connection rows, one per output
    for (genvar k = 0; k < N_OUT; k++) begin : g_row
        logic [N_TERM-1:0] row_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                row_q <= '0;
            else if (cfg_we && cfg_addr == ADDR_W'(OR_BASE + k))
                row_q <= cfg_wdata[N_TERM-1:0];
        end
        assign or_cfg[k*N_TERM +: N_TERM] = row_q;
    end

    // Output inversion register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inv_cfg <= '0;
        else if (cfg_we && cfg_addr == ADDR_W'(INV_ADDR))
            inv_cfg <= cfg_wdata[N_OUT-1:0];
    end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
    import sop_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_TERM = 48
) (
    input  logic [N_IN-1:0]          data_in,
    input  logic [N_TERM*2*N_IN-1:0] term_cfg,
    output logic [N_TERM-1:0]        term_hit
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                unique case (lit_e'(term_cfg[(t*N_IN + i)*2 +: 2]))
                    LIT_ANY:  lit_ok[i] = 1'b1;
                    LIT_POS:  lit_ok[i] = data_in[i];
                    LIT_NEG:  lit_ok[i] = ~data_in[i];
                    LIT_KILL: lit_ok[i] = 1'b0;
                    default:  lit_ok[i] = 1'b0;
                endcase
            end
        end
        assign term_hit[t] = &lit_ok;
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_TERM = 48,
    parameter int N_OUT  = 8
) (
    input  logic [N_TERM-1:0]       term_hit,
    input  logic [N_OUT*N_TERM-1:0] or_cfg,
    input  logic [N_OUT-1:0]        inv_cfg,
    output logic [N_OUT-1:0]        sum_val
);
    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic raw_or;
        assign raw_or     = |(term_hit & or_cfg[k*N_TERM +: N_TERM]);
        assign sum_val[k] = raw_or ^ inv_cfg[k];
    end
endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage #(
    parameter int N_OUT     = 8,
    parameter bit OPEN_COLL = 1'b0
) (
    input  logic             ce_n,
    input  logic [N_OUT-1:0] sum_val,
    output logic [N_OUT-1:0] drv_n,
    output logic [N_OUT-1:0] line_lvl,
    output logic             line_oe
);
    if (OPEN_COLL) begin : g_oc
        // Pull-down active (0) only when enabled and the value is 0
        assign drv_n    = ce_n ? '1 : sum_val;
        assign line_lvl = drv_n;
        assign line_oe  = 1'b1;
    end else begin : g_tri
        assign drv_n    = {N_OUT{ce_n}};
        assign line_lvl = sum_val;
        assign line_oe  = ~ce_n;
    end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int N_IN      = 16,
    parameter int N_TERM    = 48,
    parameter int N_OUT     = 8,
    parameter bit OPEN_COLL = 1'b0,
    localparam int ADDR_W   = $clog2(N_TERM + N_OUT + 1),
    localparam int DATA_W   = (2*N_IN > N_TERM) ? 2*N_IN : N_TERM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   data_in,
    input  logic              ce_n,
    output logic [N_OUT-1:0]  f_out,
    output logic [N_OUT-1:0]  drv_n
);
    logic [N_TERM*2*N_IN-1:0] term_cfg_w;
    logic [N_OUT*N_TERM-1:0]  or_cfg_w;
    logic [N_OUT-1:0]         inv_cfg_w;
    logic [N_TERM-1:0]        term_hit_w;
    logic [N_OUT-1:0]         sum_w;
    logic [N_OUT-1:0]         lvl_w;
    logic                     oe_w;

    sop_cfg_store #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .term_cfg(term_cfg_w), .or_cfg(or_cfg_w),
        .inv_cfg(inv_cfg_w)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .data_in(data_in), .term_cfg(term_cfg_w), .term_hit(term_hit_w)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term_hit(term_hit_w), .or_cfg(or_cfg_w), .inv_cfg(inv_cfg_w),
        .sum_val(sum_w)
    );

    sop_out_stage #(.N_OUT(N_OUT), .OPEN_COLL(OPEN_COLL)) u_out (
        .ce_n(ce_n), .sum_val(sum_w), .drv_n(drv_n), .line_lvl(lvl_w),
        .line_oe(oe_w)
    );

    assign f_out = oe_w ? lvl_w : 'z;
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_IN      = 16,
    parameter int N_TERM    = 48,
    parameter int N_OUT     = 8,
    parameter bit OPEN_COLL = 1'b0,
    parameter int ADDR_W    = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_we,
    input logic [ADDR_W-1:0]          cfg_addr,
    input logic [N_IN-1:0]            data_in,
    input logic                       ce_n,
    input logic [N_OUT-1:0]           f_out,
    input logic [N_OUT-1:0]           drv_n,
    input logic [N_TERM*2*N_IN-1:0]   term_cfg,
    input logic [N_OUT*N_TERM-1:0]    or_cfg,
    input logic [N_OUT-1:0]           inv_cfg,
    input logic [N_TERM-1:0]          term_hit
);
    localparam int LIT_W    = 2 * N_IN;
    localparam int INV_ADDR = N_TERM + N_OUT;

    a_r8_inhibit_release: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> drv_n == '1);

    a_r10_ignored_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > ADDR_W'(INV_ADDR)) |=>
            ($stable(term_cfg) && $stable(or_cfg) && $stable(inv_cfg)));

    a_r7_no_spurious_change: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we ##1 ($stable(data_in) && $stable(ce_n)) |->
            ($stable(drv_n) && $stable(term_hit)));

    for (genvar t = 0; t < N_TERM; t++) begin : g_dc
        a_r3_all_dont_care: assert property (@(posedge clk) disable iff (!rst_n)
            (term_cfg[t*LIT_W +: LIT_W] == '0) |-> term_hit[t]);
    end

    if (OPEN_COLL) begin : g_oc
        a_r9_resolved_level: assert property (@(posedge clk) disable iff (!rst_n)
            f_out == drv_n);
    end else begin : g_tri
        a_r9_tri_drive: assert property (@(posedge clk) disable iff (!rst_n)
            !ce_n |-> drv_n == '0);
    end
endmodule

bind sop_array sop_array_chk #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT),
    .OPEN_COLL(OPEN_COLL), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .data_in(data_in), .ce_n(ce_n), .f_out(f_out), .drv_n(drv_n),
    .term_cfg(term_cfg_w), .or_cfg(or_cfg_w), .inv_cfg(inv_cfg_w),
    .term_hit(term_hit_w)
);

// File: tb/sop_array_test.sv
module sop_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [47:0] cfg_wdata = '0;
    logic [15:0] data_in = '0;
    logic        ce_n = 1'b0;
    wire  [7:0]  f_tri, d_tri, f_oc, d_oc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit [31:0] m_term [48];
    bit [47:0] m_or [8];
    bit [7:0]  m_inv;

    always #4 clk = ~clk;

    sop_array #(.OPEN_COLL(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .data_in(data_in), .ce_n(ce_n),
        .f_out(f_tri), .drv_n(d_tri)
    );

    sop_array #(.OPEN_COLL(1'b1)) uut_oc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .data_in(data_in), .ce_n(ce_n),
        .f_out(f_oc), .drv_n(d_oc)
    );

    function automatic bit [7:0] model(bit [15:0] d);
        bit [47:0] tv;
        bit [7:0]  v;
        for (int t = 0; t < 48; t++) begin
            bit on = 1'b1;
            for (int i = 0; i < 16; i++) begin
                case (m_term[t][2*i +: 2])
                    2'b01:   on = on & d[i];
                    2'b10:   on = on & ~d[i];
                    2'b11:   on = 1'b0;
                    default: ;
                endcase
            end
            tv[t] = on;
        end
        for (int k = 0; k < 8; k++) v[k] = (|(tv & m_or[k])) ^ m_inv[k];
        return v;
    endfunction

    task automatic check_now(string req, logic [7:0] v);
        logic [7:0] e_ftri, e_dtri, e_oc;
        e_ftri = ce_n ? 8'bzzzzzzzz : v;
        e_dtri = ce_n ? 8'hff : 8'h00;
        e_oc   = ce_n ? 8'hff : v;
        checks++;
        if (f_tri !== e_ftri || d_tri !== e_dtri || f_oc !== e_oc || d_oc !== e_oc) begin
            errors++;
            $display("FAIL %s: tri f=%b drv=%b oc f=%b drv=%b, expected tri f=%b drv=%b oc %b",
                     req, f_tri, d_tri, f_oc, d_oc, e_ftri, e_dtri, e_oc);
        end
    endtask

    task automatic apply(string req, logic [15:0] d, logic ce);
        data_in = d;
        ce_n = ce;
        #1;
        check_now(req, model(d));
    endtask

    task automatic model_write(logic [5:0] a, logic [47:0] w);
        if (a < 6'd48) m_term[a] = w[31:0];
        else if (a < 6'd56) m_or[a - 6'd48] = w;
        else if (a == 6'd56) m_inv = w[7:0];
    endtask

    task automatic cfg_wr(logic [5:0] a, logic [47:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(a, w);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int t = 0; t < 48; t++) m_term[t] = '1;
        for (int k = 0; k < 8; k++) m_or[k] = '0;
        m_inv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state gives all-zero outputs when enabled
        apply("R1", 16'hffff, 1'b0);
        apply("R1", 16'h0000, 1'b0);
        // R8: inhibit while disabled
        apply("R8", 16'h1234, 1'b1);

        // R7: write is not visible before the clock edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'd56; cfg_wdata = 48'h01;
        data_in = 16'h0; ce_n = 1'b0; #1;
        check_now("R7", 8'h00);
        @(negedge clk);
        cfg_we = 1'b0;
        model_write(6'd56, 48'h01);
        apply("R7", 16'h0, 1'b0);
        // R6 and R5: inverted empty output reads 1
        apply("R6", 16'h0, 1'b0);
        cfg_wr(6'd56, 48'h80);
        apply("R5", 16'h5555, 1'b0);

        // R3: all don't-care term 0 into output 0
        cfg_wr(6'd0, 48'h0);
        cfg_wr(6'd48, 48'h1);
        apply("R3", 16'h0000, 1'b0);
        apply("R3", 16'hffff, 1'b0);

        // R2/R4: term 1 = in3 & ~in5, shared into outputs 1 and 2
        cfg_wr(6'd1, 48'h0 | (48'h1 << 6) | (48'h2 << 10));
        cfg_wr(6'd49, 48'h2);
        cfg_wr(6'd50, 48'h2);
        apply("R2", 16'h0008, 1'b0);
        apply("R2", 16'h0028, 1'b0);
        apply("R4", 16'h0000, 1'b0);

        // R2: kill code in one position forces term 2 to 0
        cfg_wr(6'd2, 48'h3 << 8);
        cfg_wr(6'd51, 48'h4);
        apply("R2", 16'h0000, 1'b0);
        apply("R2", 16'hffff, 1'b0);

        // R9: both styles, enabled and inhibited
        apply("R9", 16'h0008, 1'b0);
        apply("R9", 16'h0008, 1'b1);

        // R10: writes above the last address are ignored
        cfg_wr(6'd57, 48'hffff_ffff_ffff);
        cfg_wr(6'd63, 48'h0);
        apply("R10", 16'h0008, 1'b0);
        apply("R10", 16'hfff7, 1'b0);

        // Random configurations and inputs (R4, R6, R8, R9)
        for (int r = 0; r < 40; r++) begin
            for (int w = 0; w < 4; w++) begin
                logic [31:0] lw = '0;
                for (int i = 0; i < 16; i++) begin
                    int s = $urandom % 10;
                    lw[2*i +: 2] = (s == 0) ? 2'b01 : (s == 1) ? 2'b10 :
                                   (s == 9 && ($urandom % 4 == 0)) ? 2'b11 : 2'b00;
                end
                cfg_wr(6'($urandom % 48), {16'h0, lw});
            end
            cfg_wr(6'(48 + $urandom % 8),
                   {16'($urandom), 32'($urandom)} & {16'($urandom), 32'($urandom)});
            if ($urandom % 4 == 0) cfg_wr(6'd56, 48'($urandom % 256));
            for (int v = 0; v < 20; v++) begin
                @(negedge clk);
                apply("R4", 16'($urandom), ($urandom % 5) == 0);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule